// File: doc/BRIEF.md
# Dual-Register Inverting Bus Transceiver

This block joins two 8-bit buses, called side A and side B, and moves data between them in either direction with every bit inverted. Each direction owns one storage register. The A-to-B register loads from side A, and the B-to-A register loads from side B. A select for each direction chooses what that direction drives onto the far side. With the select low it drives the live value of the opposite bus. With the select high it drives the value held in that direction's register.

Each side is modelled as three separate signals: an input, an output, and an output-enable flag. When the block drives a side, the surrounding logic feeds the driven value back on that side's input. Because of this, a register can capture a value that the block itself is putting on the bus. That is how one bus value can be stored in both registers. The two direction enables have opposite polarity, and when both are inactive the two sides are isolated from each other.

Loading is triggered by a rising edge on a per-direction capture strobe. The strobes are sampled on the system clock. A capture happens on the clock edge where the strobe is seen high after having been low at the previous edge.

Top module: `xinv_top`

## Requirements
- R1: On a clock edge where `cap_a2b` is 1 and was 0 at the previous edge, the A-to-B register loads `a_in`. The new value is visible from the next cycle.
- R2: On a clock edge where `cap_b2a` is 1 and was 0 at the previous edge, the B-to-A register loads `b_in`. The new value is visible from the next cycle.
- R3: Capture depends only on the strobe edge, not on either enable. Both registers load while the sides are isolated. A strobe held at 1 over later edges does not reload its register.
- R4: With `sel_a2b`=0, `b_out` is the bitwise inverse of `a_in`; with `sel_a2b`=1, it is the inverse of the A-to-B register. `a_out` follows the same rule, using `sel_b2a`, `b_in` and the B-to-A register.
- R5: `b_oe` is 1 exactly when `en_a2b`=1, which is active high. `a_oe` is 1 exactly when `en_b2a_n`=0, which is active low.
- R6: An output whose enable is inactive has its oe flag at 0 and its data at all zeros. With `en_a2b`=0 and `en_b2a_n`=1, both sides are undriven.
- R7: A register captures the value present on its bus even when the block drives that bus. For example, with A driving B live, a B-to-A capture stores the inverse of `a_in`.
- R8: While `rst_n`=0, asynchronously, both registers are cleared to zero, both oe flags are 0, and both strobes are treated as previously high. A strobe that is already high when reset ends is therefore not an edge.
- R9: A change of a select changes an enabled output in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 8 | Value currently present on side A |
| b_in | input | 8 | Value currently present on side B |
| cap_a2b | input | 1 | Capture strobe of the A-to-B register (rising edge) |
| cap_b2a | input | 1 | Capture strobe of the B-to-A register (rising edge) |
| sel_a2b | input | 1 | 0: drive live A to B, 1: drive stored A-to-B value |
| sel_b2a | input | 1 | 0: drive live B to A, 1: drive stored B-to-A value |
| en_a2b | input | 1 | Active-high enable for driving side B |
| en_b2a_n | input | 1 | Active-low enable for driving side A |
| a_out | output | 8 | Inverted data driven onto side A |
| a_oe | output | 1 | Side A is driven |
| b_out | output | 8 | Inverted data driven onto side B |
| b_oe | output | 1 | Side B is driven |

## Verification
The directed patterns each separate one pair of behaviours that could be confused:
- Loading both registers in isolation and then showing them on the far side separates stored data from live data.
- Changing a select within one cycle separates a combinational mux from a registered one.
- Holding a strobe high across new bus values separates edge capture from level capture.

The store-in-both patterns make one side drive while both strobes fire. A correct register then holds an inverted copy of the opposite bus, which distinguishes capture of the bus from capture of the external source. Random enable, select, strobe and data patterns, excluding the two-way live loop, then compare all four outputs against a bench model every cycle.

// File: rtl/xinv_pkg.sv
package xinv_pkg;

    // Polarity of an output enable pin
    typedef enum logic {
        EN_ACT_HIGH = 1'b0,
        EN_ACT_LOW  = 1'b1
    } en_pol_e;

    // Resolve an enable pin to a drive request for the given polarity
    function automatic logic enable_active(input en_pol_e pol, input logic pin);
        return (pol == EN_ACT_HIGH) ? pin : !pin;
    endfunction

endpackage

// File: rtl/xinv_cap_reg.sv
module xinv_cap_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic         strobe;
        logic [W-1:0] data;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        st_d        = st_q;
        fire        = strobe && !st_q.strobe;
        st_d.strobe = strobe;
        if (fire) begin
            st_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.strobe <= 1'b1;
            st_q.data   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.data;

    // R1 / R2: a rising strobe loads the bus value seen at that edge
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !st_q.strobe) |=> (q == $past(din)));

    // R3: without a fresh strobe edge the register keeps its value
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && !st_q.strobe) |=> $stable(q));

endmodule

// File: rtl/xinv_out_path.sv
module xinv_out_path
    import xinv_pkg::*;
#(
    parameter int      W   = 8,
    parameter en_pol_e POL = EN_ACT_HIGH
) (
    input  logic         rst_n,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    input  logic         sel,
    input  logic         en,
    output logic [W-1:0] dout,
    output logic         oe
);

    logic [W-1:0] src;
    logic         drive;

    always_comb begin
        drive = rst_n && enable_active(POL, en);
        src   = sel ? stored : live;
        oe    = drive;
        dout  = drive ? ~src : '0;
    end

endmodule

// File: rtl/xinv_top.sv
module xinv_top
    import xinv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         cap_a2b,
    input  logic         cap_b2a,
    input  logic         sel_a2b,
    input  logic         sel_b2a,
    input  logic         en_a2b,
    input  logic         en_b2a_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [W-1:0] reg_a2b_q;
    logic [W-1:0] reg_b2a_q;

    xinv_cap_reg #(.W(W)) u_reg_a2b (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_a2b),
        .din    (a_in),
        .q      (reg_a2b_q)
    );

    xinv_cap_reg #(.W(W)) u_reg_b2a (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_b2a),
        .din    (b_in),
        .q      (reg_b2a_q)
    );

    xinv_out_path #(.W(W), .POL(EN_ACT_HIGH)) u_path_b (
        .rst_n  (rst_n),
        .live   (a_in),
        .stored (reg_a2b_q),
        .sel    (sel_a2b),
        .en     (en_a2b),
        .dout   (b_out),
        .oe     (b_oe)
    );

    xinv_out_path #(.W(W), .POL(EN_ACT_LOW)) u_path_a (
        .rst_n  (rst_n),
        .live   (b_in),
        .stored (reg_b2a_q),
        .sel    (sel_b2a),
        .en     (en_b2a_n),
        .dout   (a_out),
        .oe     (a_oe)
    );

    // R5: each side is driven only under its own enable polarity
    p_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe == en_a2b) && (a_oe == !en_b2a_n));

    // R6: isolation leaves both sides undriven with quiet data
    p_isolate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_a2b && en_b2a_n) |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

    // R4: live transfer toward B is the inverse of side A
    p_live_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !sel_a2b) |-> (b_out == ~a_in));

    // R4: stored transfer toward A is the inverse of the B-to-A register
    p_stored_ba_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && sel_b2a) |-> (a_out == ~reg_b2a_q));

    // R8: no side is driven while reset is held
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r8: assert (!a_oe && !b_oe);
        end
    end

endmodule

// File: tb/tb_xinv_top.sv
module tb_xinv_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic         cap_a2b, cap_b2a, sel_a2b, sel_b2a, en_a2b, en_b2a_n;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    xinv_top #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .cap_a2b(cap_a2b), .cap_b2a(cap_b2a),
        .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
        .en_a2b(en_a2b), .en_b2a_n(en_b2a_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [W-1:0] m_ra, m_rb;
    logic         m_pa, m_pb;
    logic [W-1:0] a_ext, b_ext;
    logic [W-1:0] x_abus, x_bbus, x_aout, x_bout;
    logic         x_aoe, x_boe;

    function automatic logic [W-1:0] inv(input logic [W-1:0] v);
        return ~v;
    endfunction

    // Resolve both buses from the model; the bench feeds driven values back
    task automatic resolve();
        x_aoe  = rst_n && !en_b2a_n;
        x_boe  = rst_n && en_a2b;
        x_abus = a_ext;
        x_bbus = b_ext;
        for (int i = 0; i < 3; i++) begin
            x_aout = x_aoe ? inv(sel_b2a ? m_rb : x_bbus) : '0;
            x_bout = x_boe ? inv(sel_a2b ? m_ra : x_abus) : '0;
            x_abus = x_aoe ? x_aout : a_ext;
            x_bbus = x_boe ? x_bout : b_ext;
        end
        a_in = x_abus;
        b_in = x_bbus;
    endtask

    task automatic set(input logic eab, input logic eban, input logic sab,
                       input logic sba, input logic cab, input logic cba,
                       input logic [W-1:0] av, input logic [W-1:0] bv);
        en_a2b = eab; en_b2a_n = eban; sel_a2b = sab; sel_b2a = sba;
        cap_a2b = cab; cap_b2a = cba; a_ext = av; b_ext = bv;
        resolve();
    endtask

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req);
        #2;
        check(req, "a_out", a_out, x_aout);
        check(req, "b_out", b_out, x_bout);
        check(req, "a_oe", W'(a_oe), W'(x_aoe));
        check(req, "b_oe", W'(b_oe), W'(x_boe));
    endtask

    // Advance one clock edge, updating the model with what the edge captures
    task automatic tick();
        resolve();
        if (cap_a2b && !m_pa) m_ra = x_abus;
        if (cap_b2a && !m_pb) m_rb = x_bbus;
        m_pa = cap_a2b;
        m_pb = cap_b2a;
        @(negedge clk);
        resolve();
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        m_ra = '0; m_rb = '0; m_pa = 1'b1; m_pb = 1'b1;
        // R8: enables asserted during reset must not drive
        set(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22);
        @(negedge clk);
        step("R8");
        // R8: held-high strobes at reset release are not edges
        set(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 8'h88);
        rst_n = 1'b1;
        resolve();
        tick();
        set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
        step("R8");
        check("R8", "reg_a2b via b_out", b_out, 8'hFF);

        // R6: isolation
        set(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hA5);
        step("R6");
        tick();
        // R3: both captured while isolated
        set(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'hA5);
        step("R3");
        tick();
        // R1: stored A to B
        set(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00);
        step("R1");
        check("R1", "stored to B", b_out, 8'hC3);
        tick();
        // R2: stored B to A
        set(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R2");
        check("R2", "stored to A", a_out, 8'h5A);
        tick();
        // R4 / R5: live A to B and live B to A
        set(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h12, 8'h00);
        step("R4");
        check("R4", "live to B", b_out, 8'hED);
        set(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h81);
        step("R5");
        check("R4", "live to A", a_out, 8'h7E);
        // R9: select flip within the same cycle
        set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h12, 8'h00);
        step("R9");
        check("R9", "sel high same cycle", b_out, 8'hC3);
        tick();
        // R3: held-high strobe does not reload
        set(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h40, 8'h00);
        tick();
        set(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h99, 8'h00);
        tick();
        step("R3");
        check("R3", "held strobe keeps value", b_out, 8'hBF);
        set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h99, 8'h00);
        tick();
        // R7: store A in both registers (A drives B live)
        set(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h6B, 8'h00);
        step("R7");
        tick();
        set(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R7");
        check("R7", "B-to-A holds inverse of A", a_out, 8'h6B);
        tick();
        // R7: store B in both registers (B drives A live)
        set(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'hD2);
        step("R7");
        tick();
        set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R7");
        check("R7", "A-to-B holds inverse of B", b_out, 8'hD2);
        tick();

        // Random mix, avoiding a two-way live loop
        void'($urandom(32'h5EED_0651));
        for (int n = 0; n < 400; n++) begin
            logic eab, eban, sab, sba;
            eab = 1'($urandom); eban = 1'($urandom);
            sab = 1'($urandom); sba = 1'($urandom);
            if (eab && !eban && !sab && !sba) sba = 1'b1;
            set(eab, eban, sab, sba, 1'($urandom), 1'($urandom),
                W'($urandom), W'($urandom));
            step("R4");
            tick();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule